// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block turns a 32-bit virtual address, qualified by a 4-bit context number, into a 36-bit physical address. It reads a tree of 32-bit entries held in memory. A root-address input locates the context table. The walker then descends through up to three further tables, one level at a time, using a single memory port that carries one transaction at a time.

Each entry's two low bits say what it is. It may point on to the next table, it may end the walk with a page entry, or it may stop the walk with a fault. A page entry met above the last level maps a large page. When the walk finds a page, the walker checks the access code against the requester's privilege and the read/write direction. It then sets the entry's referenced bit, and on writes also its modified bit. The entry is written back only when one of those bits actually changes.

The result comes back as a one-cycle response. A good walk returns the physical address and a cacheable flag. A failed walk returns a fault with a cause code. In both cases the response reports the level at which the walk stopped.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_valid_o` are 0.
- R2: The context entry is read at `ctx_root_i + 4*ctx`. Levels 1, 2 and 3 are indexed by virtual address bits 31:24, 23:18 and 17:12. The next table's base is the pointer entry with bits 1:0 cleared, shifted left by 4. An entry is read at that base plus 4 times the index.
- R3: The entry type is held in bits 1:0: 0 invalid, 1 pointer, 2 page, 3 reserved. An invalid entry faults with cause 0 and a reserved entry faults with cause 1. A pointer found at level 3 faults as invalid.
- R4: A page entry at level 3 gives a physical address of entry bits 31:8 followed by virtual address bits 11:0. `rsp_cache_o` equals entry bit 7.
- R5: A page entry at level 0, 1 or 2 maps a large page. At those levels, virtual address bits 31:12, 23:12 or 17:12 replace the matching low bits of the page number.
- R6: A user access to a page whose access code (entry bits 4:2) is 6 or 7 faults with cause 3.
- R7: A write faults with cause 2 when the access code grants no write right in the current mode. Writes are allowed for codes 1 and 3 in both modes, and for codes 5 and 7 in supervisor mode only. A user write to code 6 or 7 faults with cause 3 instead, as set out in R6.
- R8: After a successful walk, the page entry is rewritten at its own address with bit 5 set, and with bit 6 also set on a write. This write happens only if the entry value changes. A fault never writes.
- R9: A memory request holds its address, direction and data steady until `mem_req_ready_i` is seen. Only one transaction is open at a time. A read completes on `mem_rsp_valid_i`.
- R10: `rsp_valid_o` is a one-cycle pulse. `rsp_level_o` gives the level (0 to 3) at which the walk stopped, both for faults and for successful walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_root_i | input | 36 | Physical byte address of the context table |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_va_i | input | 32 | Virtual address |
| req_ctx_i | input | 4 | Context number |
| req_write_i | input | 1 | 1 for a write access |
| req_user_i | input | 1 | 1 for a user-mode access |
| rsp_valid_o | output | 1 | Result pulse |
| rsp_pa_o | output | 36 | Physical address |
| rsp_cache_o | output | 1 | Page is cacheable |
| rsp_fault_o | output | 1 | Walk ended in a fault |
| rsp_level_o | output | 2 | Level at which the walk stopped |
| rsp_cause_o | output | 2 | Fault cause: 0 invalid, 1 reserved, 2 protection, 3 privilege |
| mem_req_valid_o | output | 1 | Memory transaction request |
| mem_req_ready_i | input | 1 | Memory accepts the transaction |
| mem_addr_o | output | 36 | Entry byte address |
| mem_we_o | output | 1 | 1 for an entry write-back |
| mem_wdata_o | output | 32 | Updated entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Entry read data |

## Verification
The bench builds one table tree and sweeps four contexts across seventeen addresses, each in all four read/write and user/supervisor combinations.

- Contexts: one continues into the tree and the other three end at once, one with a level-0 page, one invalid and one reserved. These walks separate the four entry types at the top level.
- Last-level addresses: these cover all eight access codes with differing starting referenced and modified bits. They tell apart protection from privilege faults, and a write-back that is needed from one that is not.
- Addresses ending at levels 1 and 2: these separate large-page bit splicing from the normal page offset.

The whole sweep runs twice: once against a memory that always answers at once, and once against one that stalls both its ready signal and its read data.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int DATA_W  = 32;
  localparam int PG_OFF  = 12;
  localparam int PPN_LSB = 8;
  localparam int PPN_W   = DATA_W - PPN_LSB;
  localparam int PA_W    = PPN_W + PG_OFF;
  localparam int BASE_SH = 4;

  localparam int BIT_CACHE = 7;
  localparam int BIT_MOD   = 6;
  localparam int BIT_REF   = 5;
  localparam int CODE_LSB  = 2;

  typedef enum logic [1:0] {
    ET_INVALID  = 2'd0,
    ET_POINTER  = 2'd1,
    ET_PAGE     = 2'd2,
    ET_RESERVED = 2'd3
  } ent_type_e;

  typedef enum logic [1:0] {
    FC_INVALID   = 2'd0,
    FC_RESERVED  = 2'd1,
    FC_PROTECT   = 2'd2,
    FC_PRIVILEGE = 2'd3
  } fault_cause_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_FETCH  = 3'd1,
    S_WAIT   = 3'd2,
    S_UPDATE = 3'd3,
    S_DONE   = 3'd4
  } walk_state_e;

endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int CTX_W   = 4,
  parameter int L1_BITS = 8,
  parameter int L2_BITS = 6,
  parameter int L3_BITS = 6,
  localparam int VA_W   = L1_BITS + L2_BITS + L3_BITS + PG_OFF
) (
  input  logic [PA_W-1:0]     root_i,
  input  logic [CTX_W-1:0]    ctx_i,
  input  logic [VA_W-1:0]     va_i,
  input  logic [DATA_W-3:0]   ptr_hi_i,
  input  logic [1:0]          next_lvl_i,
  output logic [PA_W-1:0]     ctx_addr_o,
  output logic [PA_W-1:0]     next_addr_o
);
  localparam int L1_LSB = PG_OFF + L3_BITS + L2_BITS;
  localparam int L2_LSB = PG_OFF + L3_BITS;
  localparam int L3_LSB = PG_OFF;

  logic [PA_W-1:0]    base;
  logic [L1_BITS-1:0] idx;

  // pointer body (bits 31:2) sits at bit 2+BASE_SH of the byte address
  assign base = {ptr_hi_i, {(2 + BASE_SH){1'b0}}};

  always_comb begin
    idx = '0;
    case (next_lvl_i)
      2'd1:    idx = va_i[L1_LSB +: L1_BITS];
      2'd2:    idx = L1_BITS'(va_i[L2_LSB +: L2_BITS]);
      2'd3:    idx = L1_BITS'(va_i[L3_LSB +: L3_BITS]);
      default: idx = '0;
    endcase
  end

  assign ctx_addr_o  = root_i + PA_W'({ctx_i, 2'b00});
  assign next_addr_o = base + PA_W'({idx, 2'b00});
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
(
  input  logic [2:0]   code_i,
  input  logic         user_i,
  input  logic         write_i,
  output logic         ok_o,
  output fault_cause_e cause_o
);
  logic priv_fail;
  logic wr_right;
  logic prot_fail;

  // codes 6 and 7 have no user rights at all
  assign priv_fail = user_i & code_i[2] & code_i[1];
  // odd codes carry write; the upper odd pair is supervisor only
  assign wr_right  = code_i[0] & (~code_i[2] | ~user_i);
  assign prot_fail = write_i & ~wr_right;

  assign ok_o    = ~priv_fail & ~prot_fail;
  assign cause_o = priv_fail ? FC_PRIVILEGE : FC_PROTECT;

  always_comb begin
    if (user_i && write_i) begin
      assert (!ok_o || code_i == 3'd1 || code_i == 3'd3)
        else $error("p_user_write_codes_r7");
    end
  end
endmodule

// File: rtl/ptw_pa_form.sv
module ptw_pa_form
  import ptw_pkg::*;
#(
  parameter int L1_BITS = 8,
  parameter int L2_BITS = 6,
  parameter int L3_BITS = 6,
  localparam int VA_W   = L1_BITS + L2_BITS + L3_BITS + PG_OFF,
  localparam int NLVL   = 4
) (
  input  logic [PPN_W-1:0] ppn_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [1:0]       lvl_i,
  output logic [PA_W-1:0]  pa_o
);
  logic [PA_W-1:0] cand [NLVL];
  logic [PA_W-1:0] page_base;

  assign page_base = {ppn_i, {PG_OFF{1'b0}}};

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    localparam int PASS = (g == 0) ? (L1_BITS + L2_BITS + L3_BITS) :
                          (g == 1) ? (L2_BITS + L3_BITS) :
                          (g == 2) ? L3_BITS : 0;
    localparam logic [PA_W-1:0] KEEP = (PA_W'(1) << (PASS + PG_OFF)) - PA_W'(1);
    assign cand[g] = (page_base & ~KEEP) | (PA_W'(va_i) & KEEP);
  end

  assign pa_o = cand[lvl_i];
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int CTX_W   = 4,
  parameter int L1_BITS = 8,
  parameter int L2_BITS = 6,
  parameter int L3_BITS = 6,
  localparam int VA_W   = L1_BITS + L2_BITS + L3_BITS + PG_OFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   ctx_root_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [CTX_W-1:0]  req_ctx_i,
  input  logic              req_write_i,
  input  logic              req_user_i,
  output logic              rsp_valid_o,
  output logic [PA_W-1:0]   rsp_pa_o,
  output logic              rsp_cache_o,
  output logic              rsp_fault_o,
  output logic [1:0]        rsp_level_o,
  output logic [1:0]        rsp_cause_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam logic [1:0] LAST_LVL = 2'd3;

  logic rst_sn;

  walk_state_e       state_q, state_d;
  logic [1:0]        lvl_q, lvl_d;
  logic [PA_W-1:0]   addr_q, addr_d;
  logic [VA_W-1:0]   va_q, va_d;
  logic              wr_q, wr_d;
  logic              usr_q, usr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [PA_W-1:0]   pa_q, pa_d;
  logic              cache_q, cache_d;
  logic              fault_q, fault_d;
  fault_cause_e      cause_q, cause_d;
  logic              en_ctl, en_res;

  logic [PA_W-1:0]   ctx_addr, next_addr, page_pa;
  logic              perm_ok;
  fault_cause_e      perm_cause;
  ent_type_e         etype;
  logic [DATA_W-1:0] marked;

  ptw_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sn)
  );

  ptw_addr_gen #(
    .CTX_W(CTX_W), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS), .L3_BITS(L3_BITS)
  ) u_addr (
    .root_i      (ctx_root_i),
    .ctx_i       (req_ctx_i),
    .va_i        (va_q),
    .ptr_hi_i    (mem_rdata_i[DATA_W-1:2]),
    .next_lvl_i  (lvl_q + 2'd1),
    .ctx_addr_o  (ctx_addr),
    .next_addr_o (next_addr)
  );

  ptw_perm_check u_perm (
    .code_i  (mem_rdata_i[CODE_LSB +: 3]),
    .user_i  (usr_q),
    .write_i (wr_q),
    .ok_o    (perm_ok),
    .cause_o (perm_cause)
  );

  ptw_pa_form #(
    .L1_BITS(L1_BITS), .L2_BITS(L2_BITS), .L3_BITS(L3_BITS)
  ) u_pa (
    .ppn_i (mem_rdata_i[DATA_W-1:PPN_LSB]),
    .va_i  (va_q),
    .lvl_i (lvl_q),
    .pa_o  (page_pa)
  );

  assign etype  = ent_type_e'(mem_rdata_i[1:0]);
  assign marked = mem_rdata_i | (DATA_W'(1) << BIT_REF) | (DATA_W'(wr_q) << BIT_MOD);

  // next-state logic
  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    addr_d  = addr_q;
    va_d    = va_q;
    wr_d    = wr_q;
    usr_d   = usr_q;
    wdata_d = wdata_q;
    pa_d    = pa_q;
    cache_d = cache_q;
    fault_d = fault_q;
    cause_d = cause_q;
    en_ctl  = 1'b0;
    en_res  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid_i) begin
          en_ctl  = 1'b1;
          state_d = S_FETCH;
          lvl_d   = 2'd0;
          addr_d  = ctx_addr;
          va_d    = req_va_i;
          wr_d    = req_write_i;
          usr_d   = req_user_i;
        end
      end
      S_FETCH: begin
        if (mem_req_ready_i) begin
          en_ctl  = 1'b1;
          state_d = S_WAIT;
        end
      end
      S_WAIT: begin
        if (mem_rsp_valid_i) begin
          en_ctl  = 1'b1;
          en_res  = 1'b1;
          fault_d = 1'b1;
          cache_d = 1'b0;
          state_d = S_DONE;
          unique case (etype)
            ET_INVALID:  cause_d = FC_INVALID;
            ET_RESERVED: cause_d = FC_RESERVED;
            ET_POINTER: begin
              cause_d = FC_INVALID;
              if (lvl_q != LAST_LVL) begin
                en_res  = 1'b0;
                lvl_d   = lvl_q + 2'd1;
                addr_d  = next_addr;
                state_d = S_FETCH;
              end
            end
            ET_PAGE: begin
              cause_d = perm_cause;
              if (perm_ok) begin
                fault_d = 1'b0;
                pa_d    = page_pa;
                cache_d = mem_rdata_i[BIT_CACHE];
                wdata_d = marked;
                if (marked != mem_rdata_i) state_d = S_UPDATE;
              end
            end
          endcase
        end
      end
      S_UPDATE: begin
        if (mem_req_ready_i) begin
          en_ctl  = 1'b1;
          state_d = S_DONE;
        end
      end
      S_DONE: begin
        en_ctl  = 1'b1;
        state_d = S_IDLE;
      end
      default: begin
        en_ctl  = 1'b1;
        state_d = S_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= S_IDLE;
      lvl_q   <= '0;
      addr_q  <= '0;
      va_q    <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      wdata_q <= '0;
    end else if (en_ctl) begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      addr_q  <= addr_d;
      va_q    <= va_d;
      wr_q    <= wr_d;
      usr_q   <= usr_d;
      wdata_q <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pa_q    <= '0;
      cache_q <= 1'b0;
      fault_q <= 1'b0;
      cause_q <= FC_INVALID;
    end else if (en_res) begin
      pa_q    <= pa_d;
      cache_q <= cache_d;
      fault_q <= fault_d;
      cause_q <= cause_d;
    end
  end

  assign req_ready_o     = (state_q == S_IDLE);
  assign mem_req_valid_o = (state_q == S_FETCH) || (state_q == S_UPDATE);
  assign mem_we_o        = (state_q == S_UPDATE);
  assign mem_addr_o      = addr_q;
  assign mem_wdata_o     = wdata_q;
  assign rsp_valid_o     = (state_q == S_DONE);
  assign rsp_pa_o        = pa_q;
  assign rsp_cache_o     = cache_q;
  assign rsp_fault_o     = fault_q;
  assign rsp_level_o     = lvl_q;
  assign rsp_cause_o     = cause_q;

  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_req_valid_o |-> !req_ready_o);

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_valid_o |=> !rsp_valid_o);

  p_wb_marks_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_req_valid_o && mem_we_o |-> mem_wdata_o[BIT_REF] && mem_wdata_o[1:0] == 2'b10);

  p_fault_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_valid_o && rsp_fault_o |-> !$past(mem_req_valid_o && mem_we_o));
endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [35:0] ctx_root;
  logic        req_valid, req_ready, req_write, req_user;
  logic [31:0] req_va;
  logic [3:0]  req_ctx;
  logic        rsp_valid, rsp_cache, rsp_fault;
  logic [35:0] rsp_pa;
  logic [1:0]  rsp_level, rsp_cause;
  logic        m_valid, m_ready, m_we, m_rvalid;
  logic [35:0] m_addr;
  logic [31:0] m_wdata, m_rdata;

  ptw_walker u0 (
    .clk(clk), .rst_n(rst_n), .ctx_root_i(ctx_root),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .req_ctx_i(req_ctx), .req_write_i(req_write), .req_user_i(req_user),
    .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa), .rsp_cache_o(rsp_cache),
    .rsp_fault_o(rsp_fault), .rsp_level_o(rsp_level), .rsp_cause_o(rsp_cause),
    .mem_req_valid_o(m_valid), .mem_req_ready_i(m_ready), .mem_addr_o(m_addr),
    .mem_we_o(m_we), .mem_wdata_o(m_wdata), .mem_rsp_valid_i(m_rvalid),
    .mem_rdata_i(m_rdata)
  );

  // memory model
  logic [31:0] mem [0:4095];
  logic        stall;
  logic        pend;
  logic [1:0]  dly;
  logic [35:0] paddr;
  logic [31:0] cyc;
  int          wcnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ready <= 1'b0; m_rvalid <= 1'b0; m_rdata <= '0;
      pend <= 1'b0; dly <= '0; paddr <= '0; cyc <= '0;
    end else begin
      cyc      <= cyc + 1;
      m_ready  <= stall ? (cyc[1:0] != 2'd1) : 1'b1;
      m_rvalid <= 1'b0;
      if (pend) begin
        if (dly == 0) begin
          m_rvalid <= 1'b1;
          m_rdata  <= mem[paddr[13:2]];
          pend     <= 1'b0;
        end else dly <= dly - 1;
      end
      if (m_valid && m_ready) begin
        if (m_we) begin
          mem[m_addr[13:2]] <= m_wdata;
          wcnt <= wcnt + 1;
        end else begin
          pend  <= 1'b1;
          paddr <= m_addr;
          dly   <= stall ? 2'd2 : 2'd0;
        end
      end
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  function automatic logic [31:0] mkptr(input logic [35:0] base);
    return 32'((base >> 4) | 36'h1);
  endfunction

  function automatic logic [31:0] mkpage(input logic [23:0] ppn, input bit c, m, r, input logic [2:0] code);
    return {ppn, c, m, r, code, 2'b10};
  endfunction

  // tree: ctx table at 0, level1 at 0x400, level2 at 0x800, level3 at 0x900
  task automatic load_tree();
    @(negedge clk);
    for (int i = 0; i < 4096; i++) mem[i] <= 32'h0;
    @(negedge clk);
    mem[0] <= mkptr(36'h400);
    mem[1] <= mkpage(24'hC0FFEE, 1'b1, 1'b0, 1'b0, 3'd1);
    mem[2] <= 32'h0;
    mem[3] <= 32'h3;
    mem[(12'h400 >> 2) + 1] <= mkptr(36'h800);
    mem[(12'h400 >> 2) + 2] <= mkpage(24'h987654, 1'b0, 1'b0, 1'b1, 3'd7);
    mem[(12'h400 >> 2) + 3] <= 32'h0;
    mem[(12'h400 >> 2) + 4] <= 32'h3;
    mem[(12'h800 >> 2) + 2] <= mkptr(36'h900);
    mem[(12'h800 >> 2) + 3] <= mkpage(24'hF12345, 1'b1, 1'b0, 1'b0, 3'd3);
    mem[(12'h800 >> 2) + 4] <= 32'h0;
    mem[(12'h800 >> 2) + 5] <= 32'h3;
    for (int k = 0; k < 8; k++)
      mem[(12'h900 >> 2) + k] <= mkpage(24'hABC00 + 24'(k * 'h111), k[0], k[2], k[1], 3'(k));
    mem[(12'h900 >> 2) + 9]  <= mkptr(36'h900);
    mem[(12'h900 >> 2) + 10] <= 32'h3;
    @(negedge clk);
  endtask

  // independent walk model
  task automatic ref_walk(input logic [31:0] va, input logic [3:0] ctx, input bit wr, usr,
                          output logic [35:0] pa, output bit cache, fault, output logic [1:0] lvl,
                          output logic [1:0] cause, output bit wb, output logic [35:0] eaddr,
                          output logic [31:0] newe);
    logic [35:0] a;
    logic [31:0] e;
    bit done;
    int pass;
    logic [35:0] keep;
    logic [2:0] code;
    bit can_w, user_none;
    a = ctx_root + 36'(ctx) * 4;
    done = 0; fault = 0; cause = 0; pa = 0; cache = 0; wb = 0; lvl = 0; eaddr = 0; newe = 0;
    for (int l = 0; l < 4 && !done; l++) begin
      e = mem[a[13:2]];
      lvl = 2'(l);
      case (e[1:0])
        2'd0: begin fault = 1; cause = 0; done = 1; end
        2'd3: begin fault = 1; cause = 1; done = 1; end
        2'd1: begin
          if (l == 3) begin fault = 1; cause = 0; done = 1; end
          else begin
            a = (36'(e) & ~36'h3) << 4;
            if (l == 0) a = a + 36'((va >> 24) & 32'hFF) * 4;
            else if (l == 1) a = a + 36'((va >> 18) & 32'h3F) * 4;
            else a = a + 36'((va >> 12) & 32'h3F) * 4;
          end
        end
        default: begin
          done = 1;
          code = e[4:2];
          user_none = (code == 3'd6) || (code == 3'd7);
          case (code)
            3'd1, 3'd3: can_w = 1;
            3'd5, 3'd7: can_w = !usr;
            default:    can_w = 0;
          endcase
          if (usr && user_none) begin fault = 1; cause = 3; end
          else if (wr && !can_w) begin fault = 1; cause = 2; end
          else begin
            pass = (l == 0) ? 20 : (l == 1) ? 12 : (l == 2) ? 6 : 0;
            keep = (36'h1 << (pass + 12)) - 1;
            pa = ((36'(e[31:8]) << 12) & ~keep) | (36'(va) & keep);
            cache = e[7];
            newe = e | 32'h20 | (wr ? 32'h40 : 32'h0);
            wb = (newe != e);
            eaddr = a;
          end
        end
      endcase
    end
  endtask

  task automatic do_walk(input logic [31:0] va, input logic [3:0] ctx, input bit wr, usr);
    logic [35:0] epa, eaddr;
    bit ecache, efault, ewb;
    logic [1:0] elvl, ecause;
    logic [31:0] enew;
    int w0, n;
    ref_walk(va, ctx, wr, usr, epa, ecache, efault, elvl, ecause, ewb, eaddr, enew);
    w0 = wcnt;
    @(negedge clk);
    req_va = va; req_ctx = ctx; req_write = wr; req_user = usr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    chk(stall ? "R9" : "R10", "response seen", 64'(rsp_valid), 64'd1);
    chk("R2", "fault flag", 64'(rsp_fault), 64'(efault));
    chk("R10", "level", 64'(rsp_level), 64'(elvl));
    if (efault) begin
      chk(ecause == 3 ? "R6" : ecause == 2 ? "R7" : "R3", "cause", 64'(rsp_cause), 64'(ecause));
      chk("R8", "no write on fault", 64'(wcnt - w0), 64'd0);
    end else begin
      chk(elvl == 3 ? "R4" : "R5", "phys addr", 64'(rsp_pa), 64'(epa));
      chk("R4", "cacheable", 64'(rsp_cache), 64'(ecache));
      chk("R8", "write count", 64'(wcnt - w0), ewb ? 64'd1 : 64'd0);
      chk("R8", "entry after", 64'(mem[eaddr[13:2]]), 64'(enew));
    end
    @(negedge clk);
    chk("R10", "pulse ends", 64'(rsp_valid), 64'd0);
  endtask

  logic [31:0] vas [17];

  initial begin
    wcnt = 0;
    stall = 1'b0;
    ctx_root = 36'h0;
    req_valid = 0; req_va = 0; req_ctx = 0; req_write = 0; req_user = 0;
    for (int k = 0; k < 11; k++)
      vas[k] = (32'd1 << 24) | (32'd2 << 18) | (32'(k) << 12) | 32'(k * 'h1D3);
    vas[11] = (32'd1 << 24) | (32'd3 << 18) | (32'd45 << 12) | 32'h7A5;
    vas[12] = (32'd1 << 24) | (32'd4 << 18) | 32'h010;
    vas[13] = (32'd1 << 24) | (32'd5 << 18) | 32'h020;
    vas[14] = (32'd2 << 24) | 32'h00A5_B6C7;
    vas[15] = (32'd3 << 24) | 32'h0000_1234;
    vas[16] = (32'd4 << 24) | 32'h0012_3456;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "req_ready", 64'(req_ready), 64'd1);
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1", "mem_valid", 64'(m_valid), 64'd0);
    for (int p = 0; p < 2; p++) begin
      stall = (p == 1);
      load_tree();
      for (int c = 0; c < 4; c++)
        for (int v = 0; v < 17; v++)
          for (int m = 0; m < 4; m++)
            do_walk(vas[v], 4'(c), m[0], m[1]);
    end
    finish_run();
  end
endmodule